// File: doc/BRIEF.md
# Two-Source Interrupt Sequencing Controller

This block sits beside a small 8-bit processor core and decides when the core is interrupted. It serves two request sources: an external pin and a one-cycle overflow pulse from an internal timer. An 8-bit control register holds a master gate, one enable per source and one pending flag per source. The core can write the whole register, or set or clear a single bit by index.

When a source's flag and enable are both set and the master gate is open, the block raises a request to the core together with the index of the winning source. The core takes the interrupt by pulsing an acknowledge. At that edge the block clears the flag of the taken source and closes the master gate, so a second interrupt cannot nest inside the first. The gate opens again only when the core reports a return-from-interrupt. The block saves no processor status word on entry; software keeps that duty.

Top module: `irq_seq_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the register reads 0x00 and `irq_req` is low.
- R2: Register layout: bit 0 is the master gate, bit 1 is the external enable, bit 2 is the timer enable, bit 4 is the external flag and bit 5 is the timer flag. Bits 3, 6 and 7 read 0. A full write loads bits 0 to 2 from `reg_wdata`, and the other written bits have no effect.
- R3: A single-bit set or clear with `reg_bidx` from 0 to 2 changes only that bit. An index that selects a flag bit or a reserved bit changes nothing. A full write in the same cycle takes precedence over a bit operation, and a clear takes precedence over a set.
- R4: A falling edge on `ext_pin` sets the external flag at the third rising clock edge that samples the pin low. A rising edge sets nothing.
- R5: `tmr_ovf` sampled high at a rising edge sets the timer flag at that edge.
- R6: Flags are set whatever the state of the enables and the master gate. Only an acknowledge clears a flag.
- R7: `irq_req` goes high at the edge after a source's flag and enable are both set with the master gate open. It stays low while the master gate or the enable is low.
- R8: `irq_src` is 0 for the external source and 1 for the timer. When both sources qualify, the external source wins.
- R9: `irq_ack` sampled high while `irq_req` is high clears the master gate and the taken source's flag at that edge, and `irq_req` falls at the same edge. The other flag is kept. `irq_ack` while `irq_req` is low has no effect.
- R10: If a new event for a source arrives in the same cycle that the source is acknowledged, its flag stays set.
- R11: `core_reti` sets the master gate at the sampling edge and wins over a software clear in the same cycle. An acknowledge in the same cycle wins over `core_reti`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Full register write strobe |
| reg_wdata | input | 8 | Full write data |
| reg_bset | input | 1 | Single-bit set strobe |
| reg_bclr | input | 1 | Single-bit clear strobe |
| reg_bidx | input | 3 | Bit index for set or clear |
| reg_rdata | output | 8 | Register read value |
| ext_pin | input | 1 | Asynchronous external interrupt pin, idle high |
| tmr_ovf | input | 1 | Timer overflow pulse |
| irq_ack | input | 1 | Core accepts the pending request |
| core_reti | input | 1 | Core executed return-from-interrupt |
| irq_req | output | 1 | Interrupt request to the core |
| irq_src | output | 1 | Index of the requesting source |

## Verification
Three pairs of events can land on the same edge. An acknowledge can meet a fresh event from the source it takes. It can also meet a return-from-interrupt strobe. A return strobe can meet a software clear of the master gate. The bench drives each pair on one clock edge and reads the register at the next negedge: the flag must stay set in the first case, the gate must end closed in the second and open in the third. Source priority is checked the same way: both flags are raised with the gate shut, then the gate is opened in one step and the bench checks which index is presented first.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  localparam int DATA_W     = 8;
  localparam int NUM_SRC    = 2;
  localparam int SRC_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int IDX_W      = $clog2(DATA_W);
  localparam int BIT_MASTER = 0;
  localparam int EN_BASE    = 1;
  localparam int FLAG_BASE  = 4;
  localparam int CTL_W      = 1 + NUM_SRC;

  typedef enum logic [SRC_W-1:0] {
    SRC_EXT = 'd0,
    SRC_TMR = 'd1
  } irq_src_e;

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o
);

  logic [STAGES:0] chain_q;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q[g] <= IDLE;
        end else begin
          if (g == 0) chain_q[g] <= pin_i;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  // chain_q[STAGES-1] is the synchronized level, chain_q[STAGES] its previous value
  assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];

endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import irq_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               bset_i,
  input  logic               bclr_i,
  input  logic [IDX_W-1:0]   bidx_i,
  input  logic [NUM_SRC-1:0] event_i,
  input  logic               take_i,
  input  logic [SRC_W-1:0]   take_src_i,
  input  logic               reti_i,
  output logic               master_o,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] flag_o,
  output logic [DATA_W-1:0]  rdata_o
);

  logic [CTL_W-1:0]   ctl_q, ctl_d;
  logic               ctl_we;
  logic [NUM_SRC-1:0] flag_q, flag_d;
  logic               flag_we;
  logic               idx_ok;

  assign idx_ok = (int'(bidx_i) < CTL_W);

  // control bits: software, then return strobe, then hardware take
  always_comb begin
    ctl_d = ctl_q;
    if (wr_i) begin
      ctl_d = wdata_i[CTL_W-1:0];
    end else if (bclr_i) begin
      if (idx_ok) ctl_d[bidx_i] = 1'b0;
    end else if (bset_i) begin
      if (idx_ok) ctl_d[bidx_i] = 1'b1;
    end
    if (reti_i) ctl_d[BIT_MASTER] = 1'b1;
    if (take_i) ctl_d[BIT_MASTER] = 1'b0;
  end

  assign ctl_we = wr_i | bset_i | bclr_i | reti_i | take_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_we) begin
      ctl_q <= ctl_d;
    end
  end

  genvar s;
  generate
    for (s = 0; s < NUM_SRC; s++) begin : g_flag
      always_comb begin
        flag_d[s] = flag_q[s];
        if (take_i && (int'(take_src_i) == s)) flag_d[s] = 1'b0;
        if (event_i[s])                        flag_d[s] = 1'b1;
      end
    end
  endgenerate

  assign flag_we = take_i | (|event_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else if (flag_we) begin
      flag_q <= flag_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[BIT_MASTER] = ctl_q[BIT_MASTER];
    for (int i = 0; i < NUM_SRC; i++) begin
      rdata_o[EN_BASE + i]   = ctl_q[1 + i];
      rdata_o[FLAG_BASE + i] = flag_q[i];
    end
  end

  assign master_o = ctl_q[BIT_MASTER];
  assign en_o     = ctl_q[CTL_W-1:1];
  assign flag_o   = flag_q;

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               master_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] flag_i,
  input  logic               ack_i,
  output logic               req_o,
  output logic [SRC_W-1:0]   src_o,
  output logic               take_o,
  output logic [SRC_W-1:0]   take_src_o
);

  logic [NUM_SRC-1:0] pend;
  logic               pend_any;
  logic [SRC_W-1:0]   win;
  logic               req_q, req_d;
  logic [SRC_W-1:0]   src_q, src_d;

  assign pend     = flag_i & en_i & {NUM_SRC{master_i}};
  assign pend_any = |pend;

  // lowest index has the highest priority
  always_comb begin
    win = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i]) win = SRC_W'(i);
    end
  end

  assign take_o     = ack_i & req_q;
  assign take_src_o = src_q;

  always_comb begin
    req_d = pend_any & ~take_o;
    src_d = pend_any ? win : src_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      src_q <= '0;
    end else begin
      req_q <= req_d;
      src_q <= src_d;
    end
  end

  assign req_o = req_q;
  assign src_o = src_q;

endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_bset,
  input  logic              reg_bclr,
  input  logic [IDX_W-1:0]  reg_bidx,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ext_pin,
  input  logic              tmr_ovf,
  input  logic              irq_ack,
  input  logic              core_reti,
  output logic              irq_req,
  output logic [SRC_W-1:0]  irq_src
);

  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic               ext_fall;
  logic [NUM_SRC-1:0] events;
  logic               master;
  logic [NUM_SRC-1:0] en;
  logic [NUM_SRC-1:0] flag;
  logic               take;
  logic [SRC_W-1:0]   take_src;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  irq_pin_sync #(
    .STAGES (SYNC_STAGES),
    .IDLE   (1'b1)
  ) u_pin_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .pin_i  (ext_pin),
    .fall_o (ext_fall)
  );

  always_comb begin
    events          = '0;
    events[SRC_EXT] = ext_fall;
    events[SRC_TMR] = tmr_ovf;
  end

  irq_ctrl_reg u_ctrl_reg (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_i       (reg_wr),
    .wdata_i    (reg_wdata),
    .bset_i     (reg_bset),
    .bclr_i     (reg_bclr),
    .bidx_i     (reg_bidx),
    .event_i    (events),
    .take_i     (take),
    .take_src_i (take_src),
    .reti_i     (core_reti),
    .master_o   (master),
    .en_o       (en),
    .flag_o     (flag),
    .rdata_o    (reg_rdata)
  );

  irq_arbiter u_arbiter (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .master_i   (master),
    .en_i       (en),
    .flag_i     (flag),
    .ack_i      (irq_ack),
    .req_o      (irq_req),
    .src_o      (irq_src),
    .take_o     (take),
    .take_src_o (take_src)
  );

endmodule

// File: rtl/irq_seq_ctrl_chk.sv
module irq_seq_ctrl_chk
  import irq_seq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq_ack,
  input logic              core_reti,
  input logic              irq_req,
  input logic [SRC_W-1:0]  irq_src
);

  logic pend_ext, pend_tmr;
  assign pend_ext = reg_rdata[FLAG_BASE] & reg_rdata[EN_BASE] & reg_rdata[BIT_MASTER];
  assign pend_tmr = reg_rdata[FLAG_BASE+1] & reg_rdata[EN_BASE+1] & reg_rdata[BIT_MASTER];

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[3] == 1'b0) && (reg_rdata[7:6] == 2'b00));

  assert_req_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(pend_ext | pend_tmr));

  assert_master_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[BIT_MASTER] |=> !irq_req);

  assert_ext_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((irq_src == SRC_EXT) == $past(pend_ext)));

  assert_take_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> (!reg_rdata[BIT_MASTER] && !irq_req));

  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_rdata[FLAG_BASE+1]) |-> $past(irq_ack && irq_req && (irq_src == SRC_TMR)));

  assert_reti_opens_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (core_reti && !(irq_ack && irq_req)) |=> reg_rdata[BIT_MASTER]);

endmodule

bind irq_seq_ctrl irq_seq_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_rdata (reg_rdata),
  .irq_ack   (irq_ack),
  .core_reti (core_reti),
  .irq_req   (irq_req),
  .irq_src   (irq_src)
);

// File: tb/irq_seq_ctrl_tb_top.sv
module irq_seq_ctrl_tb_top;

  logic       clk;
  logic       rst_n;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic       reg_bset;
  logic       reg_bclr;
  logic [2:0] reg_bidx;
  logic [7:0] reg_rdata;
  logic       ext_pin;
  logic       tmr_ovf;
  logic       irq_ack;
  logic       core_reti;
  logic       irq_req;
  logic [0:0] irq_src;

  int checks = 0;
  int errors = 0;

  irq_seq_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_bset  (reg_bset),
    .reg_bclr  (reg_bclr),
    .reg_bidx  (reg_bidx),
    .reg_rdata (reg_rdata),
    .ext_pin   (ext_pin),
    .tmr_ovf   (tmr_ovf),
    .irq_ack   (irq_ack),
    .core_reti (core_reti),
    .irq_req   (irq_req),
    .irq_src   (irq_src)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // row: {wr,bset,bclr,idx[2:0],wdata[7:0],pin,tovf,ack,reti, exp_rd[7:0],exp_req,exp_src}
  localparam int NROW = 21;
  localparam logic [27:0] TBL [NROW] = '{
    {1'b0,1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,1'b0,1'b0, 8'h00,1'b0,1'b0}, // R1 idle
    {1'b1,1'b0,1'b0,3'd0,8'hFF,1'b1,1'b0,1'b0,1'b0, 8'h07,1'b0,1'b0}, // R2 full write
    {1'b0,1'b0,1'b0,3'd0,8'h00,1'b1,1'b1,1'b0,1'b0, 8'h27,1'b0,1'b0}, // R5 overflow
    {1'b0,1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,1'b0,1'b0, 8'h27,1'b1,1'b1}, // R7 request
    {1'b0,1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,1'b1,1'b0, 8'h06,1'b0,1'b0}, // R9 take
    {1'b0,1'b0,1'b0,3'd0,8'h00,1'b1,1'b1,1'b0,1'b0, 8'h26,1'b0,1'b0}, // R6 flag, gate shut
    {1'b0,1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,1'b0,1'b0, 8'h26,1'b0,1'b0}, // R7 gate blocks
    {1'b0,1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,1'b0,1'b1, 8'h27,1'b0,1'b0}, // R11 return
    {1'b0,1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,1'b0,1'b0, 8'h27,1'b1,1'b1}, // R7 request
    {1'b0,1'b0,1'b0,3'd0,8'h00,1'b0,1'b0,1'b0,1'b0, 8'h27,1'b1,1'b1}, // R4 pin low 1
    {1'b0,1'b0,1'b0,3'd0,8'h00,1'b0,1'b0,1'b0,1'b0, 8'h27,1'b1,1'b1}, // R4 pin low 2
    {1'b0,1'b0,1'b0,3'd0,8'h00,1'b0,1'b0,1'b0,1'b0, 8'h37,1'b1,1'b1}, // R4 flag lands
    {1'b0,1'b0,1'b0,3'd0,8'h00,1'b0,1'b0,1'b0,1'b0, 8'h37,1'b1,1'b0}, // R8 external wins
    {1'b0,1'b0,1'b0,3'd0,8'h00,1'b0,1'b0,1'b1,1'b0, 8'h26,1'b0,1'b0}, // R9 take external
    {1'b0,1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,1'b0,1'b1, 8'h27,1'b0,1'b0}, // R11 return
    {1'b0,1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,1'b0,1'b0, 8'h27,1'b1,1'b1}, // R4 rise sets nothing
    {1'b0,1'b0,1'b0,3'd0,8'h00,1'b1,1'b1,1'b1,1'b0, 8'h26,1'b0,1'b0}, // R10 take plus event
    {1'b0,1'b1,1'b0,3'd0,8'h00,1'b1,1'b0,1'b0,1'b0, 8'h27,1'b0,1'b0}, // R3 set bit 0
    {1'b0,1'b0,1'b1,3'd2,8'h00,1'b1,1'b0,1'b0,1'b0, 8'h23,1'b1,1'b1}, // R3 clear bit 2
    {1'b0,1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,1'b0,1'b0, 8'h23,1'b0,1'b0}, // R7 enable blocks
    {1'b1,1'b0,1'b0,3'd0,8'h30,1'b1,1'b0,1'b0,1'b0, 8'h20,1'b0,1'b0}  // R2 flag bits ignored
  };

  function automatic string row_tag(input int r);
    case (r)
      0:            return "R1";
      1, 20:        return "R2";
      17, 18:       return "R3";
      9, 10, 11, 15: return "R4";
      2:            return "R5";
      5:            return "R6";
      3, 6, 8, 19:  return "R7";
      12:           return "R8";
      4, 13:        return "R9";
      16:           return "R10";
      default:      return "R11";
    endcase
  endfunction

  task automatic drive(input logic wr, input logic bs, input logic bc, input logic [2:0] idx,
                       input logic [7:0] wd, input logic pin, input logic to,
                       input logic ack, input logic reti);
    @(negedge clk);
    reg_wr = wr; reg_bset = bs; reg_bclr = bc; reg_bidx = idx; reg_wdata = wd;
    ext_pin = pin; tmr_ovf = to; irq_ack = ack; core_reti = reti;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string tag, input logic [7:0] rd, input logic rq, input logic sr);
    checks++;
    if (reg_rdata !== rd) begin
      errors++;
      $display("FAIL %s reg_rdata actual %02h expected %02h", tag, reg_rdata, rd);
    end
    checks++;
    if (irq_req !== rq || (rq && irq_src !== sr)) begin
      errors++;
      $display("FAIL %s req/src actual %b/%0d expected %b/%0d", tag, irq_req, irq_src, rq, sr);
    end
  endtask

  task automatic idle(input logic pin);
    drive(1'b0, 1'b0, 1'b0, 3'd0, 8'h00, pin, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0;
    reg_wr = 1'b0; reg_bset = 1'b0; reg_bclr = 1'b0; reg_bidx = 3'd0; reg_wdata = 8'h00;
    ext_pin = 1'b1; tmr_ovf = 1'b0; irq_ack = 1'b0; core_reti = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    expect_out("R1", 8'h00, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    expect_out("R1", 8'h00, 1'b0, 1'b0);

    for (int r = 0; r < NROW; r++) begin
      drive(TBL[r][27], TBL[r][26], TBL[r][25], TBL[r][24:22], TBL[r][21:14],
            TBL[r][13], TBL[r][12], TBL[r][11], TBL[r][10]);
      expect_out(row_tag(r), TBL[r][9:2], TBL[r][1], TBL[r][0]);
    end

    // R3: index onto flag or reserved bits has no effect
    drive(1'b0, 1'b1, 1'b0, 3'd4, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_out("R3", 8'h20, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b1, 3'd5, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_out("R3", 8'h20, 1'b0, 1'b0);
    drive(1'b0, 1'b1, 1'b0, 3'd7, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_out("R3", 8'h20, 1'b0, 1'b0);
    // R3: full write beats bit set
    drive(1'b1, 1'b1, 1'b0, 3'd0, 8'h02, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_out("R3", 8'h22, 1'b0, 1'b0);
    // R3: clear beats set
    drive(1'b0, 1'b1, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_out("R3", 8'h23, 1'b0, 1'b0);
    drive(1'b0, 1'b1, 1'b1, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_out("R3", 8'h22, 1'b0, 1'b0);
    // R9: acknowledge with no request is ignored
    drive(1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0);
    expect_out("R9", 8'h22, 1'b0, 1'b0);
    // R11: return strobe beats software clear of the gate
    drive(1'b0, 1'b0, 1'b1, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1);
    expect_out("R11", 8'h23, 1'b0, 1'b0);
    // R11: acknowledge beats return strobe
    drive(1'b0, 1'b1, 1'b0, 3'd2, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_out("R3", 8'h27, 1'b0, 1'b0);
    idle(1'b1);
    expect_out("R7", 8'h27, 1'b1, 1'b1);
    drive(1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1);
    expect_out("R11", 8'h06, 1'b0, 1'b0);

    // R8: both flags pending when the gate opens
    drive(1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0);
    expect_out("R6", 8'h26, 1'b0, 1'b0);
    idle(1'b0);
    idle(1'b0);
    idle(1'b0);
    expect_out("R4", 8'h36, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1);
    expect_out("R11", 8'h37, 1'b0, 1'b0);
    idle(1'b1);
    expect_out("R8", 8'h37, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0);
    expect_out("R9", 8'h26, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1);
    expect_out("R11", 8'h27, 1'b0, 1'b0);
    idle(1'b1);
    expect_out("R8", 8'h27, 1'b1, 1'b1);
    drive(1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0);
    expect_out("R9", 8'h06, 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule